// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the address for each access of a short burst on a synchronous memory. A caller presents one starting address together with a load command. On each later cycle it raises the advance command, and the block steps the low address bits through the burst while the upper bits stay fixed. A burst has at most 2**LOW_W beats, which is four beats at the default setting.

Two beat orders are available. In linear order the low bits count up and wrap inside the aligned group. In interleaved order beat k uses the start value XOR k. A static select input picks the order. A wait input freezes the sequencer for any number of cycles. A flag reports whether a burst is still in progress.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge with `wait_st` low and `adv_ld` low, the sequencer captures `ext_addr`. From the next cycle, `cur_addr` equals that address and `burst_act` is 1.
- R2: On a rising edge with `wait_st` low and `adv_ld` high, `ext_addr` is ignored. `cur_addr` depends only on the captured address and the beat count.
- R3: With `order_sel` = 0 (linear), the low two bits count up by one per advance and wrap within the group of four. Start 01 gives 01,10,11,00. Start 11 gives 11,00,01,10.
- R4: With `order_sel` = 1 (interleaved), beat k uses start XOR k on the low two bits. Start 01 gives 01,00,11,10. Start 10 gives 10,11,00,01.
- R5: The value 1 on `order_sel` selects interleaved order, and 0 selects linear order. Interleaved is the intended default wiring.
- R6: While `wait_st` is 1 at a rising edge, the sequencer neither loads nor advances. `cur_addr` and `burst_act` keep their values.
- R7: The address bits above the low LOW_W bits always equal the bits captured at the last load.
- R8: An advance taken on the last beat clears `burst_act`. The beat index and `cur_addr` then hold at the last beat's values until a new load.
- R9: A synchronous reset (`rst` high at a rising edge) clears the beat index, the captured address and `burst_act`, so `cur_addr` reads 0.
- R10: An advance while `burst_act` is 0 changes neither `cur_addr` nor `burst_act`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wait_st | input | 1 | 1 = ignore this edge (wait state) |
| adv_ld | input | 1 | 0 = load `ext_addr`, 1 = advance the burst |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| ext_addr | input | ADDR_W | External starting address |
| cur_addr | output | ADDR_W | Address for the current beat |
| burst_act | output | 1 | 1 while beats of the current burst remain |

## Verification
The hardest cases to reach from the ports are the edges of a burst. One is an advance on the fourth beat, and another is a wait state that lands exactly on that beat. A third is an advance issued while the sequencer is idle. In each of these the flag and the address must freeze, even though `ext_addr` keeps changing. Directed sequences force each of these cases with a changing `ext_addr` on every cycle. A long random run then mixes loads, advances, waits, order changes and resets, and a behavioural model follows it cycle by cycle.

// File: rtl/bas_pkg.sv
package bas_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;
endpackage

// File: rtl/bas_addr_reg.sv
module bas_addr_reg #(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (capture) q <= d;
   end

   // R1: a capture is visible on the following cycle
   p_capture_r1: assert property (@(posedge clk) disable iff (rst)
      capture |=> q == $past(d));
   // R7: without a capture the stored address holds
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !capture |=> $stable(q));
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr #(
   parameter int LOW_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wait_st,
   input  logic             adv_ld,
   output logic [LOW_W-1:0] beat,
   output logic             active
);
   localparam logic [LOW_W-1:0] LAST_BEAT = {LOW_W{1'b1}};

   logic do_load, do_step;
   assign do_load = !wait_st && !adv_ld;
   assign do_step = !wait_st &&  adv_ld && active;

   always_ff @(posedge clk) begin
      if (rst) begin
         beat   <= '0;
         active <= 1'b0;
      end else if (do_load) begin
         beat   <= '0;
         active <= 1'b1;
      end else if (do_step) begin
         if (beat == LAST_BEAT) active <= 1'b0;
         else                   beat   <= beat + 1'b1;
      end
   end

   // R9: reset clears the index and the flag
   p_reset_r9: assert property (@(posedge clk)
      rst |=> (beat == '0) && !active);
   // R6: a wait state freezes the counter
   p_wait_r6: assert property (@(posedge clk) disable iff (rst)
      wait_st |=> $stable(beat) && $stable(active));
   // R10: an advance while idle changes nothing
   p_idle_r10: assert property (@(posedge clk) disable iff (rst)
      (!wait_st && adv_ld && !active) |=> $stable(beat) && !active);
   // R8: the last beat ends the burst and the index holds
   p_end_r8: assert property (@(posedge clk) disable iff (rst)
      (!wait_st && adv_ld && active && beat == LAST_BEAT) |=> !active && $stable(beat));
   // R3: an earlier beat steps the index by one
   p_step_r3: assert property (@(posedge clk) disable iff (rst)
      (!wait_st && adv_ld && active && beat != LAST_BEAT) |=> active && beat == $past(beat) + 1'b1);
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
   import bas_pkg::*;
#(
   parameter int LOW_W          = 2,
   parameter bit HAS_LINEAR     = 1'b1,
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  logic [LOW_W-1:0] start,
   input  logic [LOW_W-1:0] beat,
   input  logic             order_sel,
   output logic [LOW_W-1:0] low
);
   logic [LOW_W-1:0] lin_low, xor_low;

   generate
      if (HAS_LINEAR) begin : g_lin
         assign lin_low = start + beat;
      end else begin : g_no_lin
         assign lin_low = '0;
      end
      if (HAS_INTERLEAVE) begin : g_xor
         assign xor_low = start ^ beat;
      end else begin : g_no_xor
         assign xor_low = '0;
      end

      if (HAS_LINEAR && HAS_INTERLEAVE) begin : g_both
         always_comb begin
            unique case (order_e'(order_sel))
               ORD_LINEAR:     low = lin_low;
               ORD_INTERLEAVE: low = xor_low;
               default:        low = xor_low;
            endcase
         end
      end else if (HAS_LINEAR) begin : g_only_lin
         assign low = lin_low;
      end else begin : g_only_xor
         assign low = xor_low;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
   parameter int ADDR_W         = 17,
   parameter int LOW_W          = 2,
   parameter bit HAS_LINEAR     = 1'b1,
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wait_st,
   input  logic              adv_ld,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              burst_act
);
   localparam int UP_W = ADDR_W - LOW_W;

   generate
      if (LOW_W < 1 || LOW_W > 4) begin : g_bad_low
         $error("burst_addr_seq: LOW_W must lie in 1..4");
      end
      if (UP_W < 1) begin : g_bad_addr
         $error("burst_addr_seq: ADDR_W must exceed LOW_W");
      end
      if (!HAS_LINEAR && !HAS_INTERLEAVE) begin : g_bad_order
         $error("burst_addr_seq: at least one beat order is required");
      end
   endgenerate

   logic [ADDR_W-1:0] base_q;
   logic [LOW_W-1:0]  beat_q;
   logic [LOW_W-1:0]  low_addr;
   logic              load_now;

   assign load_now = !wait_st && !adv_ld;

   bas_addr_reg #(.ADDR_W(ADDR_W)) i_addr (
      .clk     (clk),
      .rst     (rst),
      .capture (load_now),
      .d       (ext_addr),
      .q       (base_q)
   );

   bas_beat_ctr #(.LOW_W(LOW_W)) i_ctr (
      .clk     (clk),
      .rst     (rst),
      .wait_st (wait_st),
      .adv_ld  (adv_ld),
      .beat    (beat_q),
      .active  (burst_act)
   );

   bas_order_map #(
      .LOW_W          (LOW_W),
      .HAS_LINEAR     (HAS_LINEAR),
      .HAS_INTERLEAVE (HAS_INTERLEAVE)
   ) i_map (
      .start     (base_q[LOW_W-1:0]),
      .beat      (beat_q),
      .order_sel (order_sel),
      .low       (low_addr)
   );

   assign cur_addr = {base_q[ADDR_W-1:LOW_W], low_addr};

   // R1: a load shows the external address and raises the flag
   p_load_r1: assert property (@(posedge clk) disable iff (rst)
      load_now |=> cur_addr == $past(ext_addr) && burst_act);
   // R7: advancing never disturbs the upper bits
   p_upper_r7: assert property (@(posedge clk) disable iff (rst)
      (!wait_st && adv_ld) |=> $stable(cur_addr[ADDR_W-1:LOW_W]));
   // R3: linear order steps the low bits by one
   p_lin_r3: assert property (@(posedge clk) disable iff (rst)
      (!wait_st && adv_ld && burst_act && !order_sel && beat_q != {LOW_W{1'b1}})
      |=> order_sel || cur_addr[LOW_W-1:0] == $past(cur_addr[LOW_W-1:0]) + 1'b1);
endmodule

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst, wait_st, adv_ld, order_sel;
   logic [AW-1:0] ext_addr;
   logic [AW-1:0] cur_addr;
   logic          burst_act;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   int m_base, m_k, m_act;

   always #2.5 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
      .clk(clk), .rst(rst), .wait_st(wait_st), .adv_ld(adv_ld),
      .order_sel(order_sel), .ext_addr(ext_addr),
      .cur_addr(cur_addr), .burst_act(burst_act)
   );

   function automatic int exp_addr();
      int lo;
      if (order_sel) lo = (m_base % 4) ^ m_k;
      else           lo = ((m_base % 4) + m_k) % 4;
      return (m_base / 4) * 4 + lo;
   endfunction

   task automatic chk(input string tag, input int act, input int expv);
      n_checks++;
      if (act != expv) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
      end
   endtask

   // one clock: drive at negedge, update the model at the edge, compare 1 ns later
   task automatic cyc(input bit r, input bit w, input bit a, input bit o, input int ad,
                      input string tag);
      rst = r; wait_st = w; adv_ld = a; order_sel = o; ext_addr = AW'(ad);
      @(posedge clk);
      if (r) begin
         m_base = 0; m_k = 0; m_act = 0;
      end else if (!w) begin
         if (!a) begin
            m_base = ad; m_k = 0; m_act = 1;
         end else if (m_act == 1) begin
            if (m_k == 3) m_act = 0;
            else          m_k++;
         end
      end
      #1;
      chk({tag, " addr"}, int'(cur_addr), exp_addr());
      chk({tag, " act"}, int'(burst_act), m_act);
      @(negedge clk);
   endtask

   task automatic burst(input bit o, input int start, input int e0, input int e1,
                        input int e2, input int e3, input string tag);
      int exp_lo[4];
      exp_lo = '{e0, e1, e2, e3};
      cyc(0, 0, 0, o, start, tag);
      chk({tag, " beat0"}, int'(cur_addr[1:0]), exp_lo[0]);
      for (int i = 1; i < 4; i++) begin
         cyc(0, 0, 1, o, 'h1ACE0 + i, tag);
         chk({tag, " beat"}, int'(cur_addr[1:0]), exp_lo[i]);
         chk({tag, " upper R7"}, int'(cur_addr[AW-1:2]), start / 4);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      m_base = 0; m_k = 0; m_act = 0;
      rst = 1; wait_st = 0; adv_ld = 1; order_sel = 1; ext_addr = '0;
      @(negedge clk);
      cyc(1, 0, 0, 1, 'h1F, "R9 reset");
      chk("R9 reset addr zero", int'(cur_addr), 0);
      chk("R9 reset act", int'(burst_act), 0);
      cyc(0, 0, 1, 1, 'h55, "R10 idle advance");
      chk("R10 addr unchanged", int'(cur_addr), 0);

      burst(0, 'h12345, 1, 2, 3, 0, "R3 linear 01");
      burst(0, 'h0ABC7, 3, 0, 1, 2, "R3 linear 11");
      burst(1, 'h10001, 1, 0, 3, 2, "R4 interleave 01");
      burst(1, 'h0F0F2, 2, 3, 0, 1, "R4 interleave 10");
      burst(1, 'h00003, 3, 2, 1, 0, "R5 sel1 interleave");
      burst(0, 'h00002, 2, 3, 0, 1, "R5 sel0 linear");

      // R8: advance past beat four ends the burst, then holds
      cyc(0, 0, 1, 0, 'h1FFFF, "R8 end");
      chk("R8 flag cleared", int'(burst_act), 0);
      chk("R8 addr held", int'(cur_addr), 'h00001);
      cyc(0, 0, 1, 0, 'h0AAAA, "R8 hold");
      chk("R8 still held", int'(cur_addr), 'h00001);

      // R6: wait states, including on the last beat
      cyc(0, 0, 0, 1, 'h04446, "R1 load");
      chk("R1 load addr", int'(cur_addr), 'h04446);
      chk("R1 load act", int'(burst_act), 1);
      cyc(0, 1, 0, 1, 'h1234C, "R6 wait on load");
      chk("R6 load ignored", int'(cur_addr), 'h04446);
      cyc(0, 0, 1, 1, 'h11111, "R2 advance");
      chk("R2 ext ignored", int'(cur_addr), 'h04447);
      cyc(0, 0, 1, 1, 'h11111, "R4 step");
      cyc(0, 0, 1, 1, 'h11111, "R4 step");
      cyc(0, 1, 1, 1, 'h11111, "R6 wait last");
      chk("R6 act kept", int'(burst_act), 1);
      cyc(0, 1, 0, 1, 'h22222, "R6 wait last");
      chk("R6 addr kept", int'(cur_addr), 'h04445);
      cyc(0, 0, 1, 1, 'h22222, "R8 end");
      chk("R8 act low", int'(burst_act), 0);

      // random mix against the model
      for (int i = 0; i < 3000; i++) begin
         cyc(($urandom % 97) == 0, ($urandom % 5) == 0, ($urandom % 10) >= 3,
             ($urandom % 50) != 0 ? order_sel : ~order_sel,
             int'($urandom % (1 << AW)), "R2 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule